// File: doc/BRIEF.md
# I2C Clock Prescale Calculator

This block turns a core clock frequency into the 16-bit prescale word that an I2C engine loads into its timing logic. The core clock arrives as an unsigned count in units of 10 kHz, together with a bus rate code and a two-bit mode that picks one of three formulas. A single start pulse captures the inputs. After a variable number of cycles the block raises a one-cycle done strobe and presents the packed word, which it then holds until the next computation finishes.

All divisions share one restoring shift-subtract divider that produces one quotient bit per cycle. The closed-form modes need one division. The search mode first divides down to an intermediate value and then tries loop indices in ascending order, one division each, until the quotient drops below the index. The latency therefore depends on the clock value. Software or a sequencer waits for the strobe and does not count cycles.

Top module: `prescale_calc`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `prescale_o` is 0x0000.
- R2: Mode 0 (search) computes nm = (sclk*10)/(rate*4). It finds the smallest index i in 1..254 with nm/i < i, sets N = i-1 and M = i-2, and outputs M in bits 7:0 and N in bits 15:8. All divisions truncate.
- R3: In mode 0, nm = 0 stops at index 1. M then wraps to 0xFF and N is 0, so the output is 0x00FF.
- R4: In mode 0, if no index up to 254 meets the condition, the index saturates at 255 and the output is 0xFEFD.
- R5: Mode 1 (fixed low byte) outputs ((sclk*10)/51200 + 1)*256 + 128, truncated to 16 bits.
- R6: Mode 2 (fixed high byte) outputs 127*256 + (sclk*10)/(508*rate), truncated to 16 bits.
- R7: Mode 3 outputs 0x0000 without a division.
- R8: `busy_o` is high from the cycle after an accepted start until the result is produced. `done_o` is a single-cycle pulse that comes with the new `prescale_o`.
- R9: A start that arrives while `busy_o` is high is ignored. It does not change the running result and does not queue a second computation.
- R10: `prescale_o` changes only in the cycle where `done_o` is high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; inputs are captured when idle |
| mode_i | input | 2 | 0 search, 1 fixed low byte, 2 fixed high byte, 3 zero |
| sclk_i | input | SCLK_W (16) | Core clock in units of 10 kHz |
| rate_i | input | RATE_W (8) | Bus rate code used as divisor term |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle strobe: result valid |
| prescale_o | output | 16 | Packed prescale word, held between results |

## Verification
The assertions check the following on every cycle:
- the done strobe is one cycle wide and comes only at the end of a busy period;
- the output word holds steady outside the strobe;
- the captured mode does not move while busy;
- the search index stays inside 1..254 and the divider count never underflows.

Only the bench scenarios can show that the formulas produce the right numbers. They cover the search stop point across several clock values, the wrap at index 1, the saturation at 255, and the closed-form results. They also show that a start issued mid-computation leaves the first result intact and starts nothing afterwards.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_FIX_LO = 2'd1,
    MODE_FIX_HI = 2'd2,
    MODE_ZERO   = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEARCH,
    ST_FIN
  } pstate_e;

  localparam int unsigned FIX_LO_DIVISOR = 51200;
  localparam int unsigned FIX_LO_BYTE    = 128;
  localparam int unsigned FIX_HI_BYTE    = 127;
  localparam int unsigned FIX_HI_SCALE   = 508;
  localparam int unsigned IDX_LAST       = 254;
endpackage

// File: rtl/prescale_div.sv
module prescale_div #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  acc_q, dvs_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial, diff;
  logic          fit;

  always_comb begin
    trial = {rem_q, acc_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fit   = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        acc_q  <= dividend_i;
        dvs_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= fit ? diff[W-1:0] : trial[W-1:0];
        acc_q <= {acc_q[W-2:0], fit};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = acc_q;

  p_div_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q != '0);
  p_div_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/prescale_pack.sv
module prescale_pack
  import prescale_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  pmode_e       mode_i,
  input  logic [W-1:0] quot_i,
  input  logic [7:0]   idx_i,
  output logic [15:0]  word_o
);
  logic [31:0] q32;

  always_comb begin
    q32 = 32'(quot_i);
    unique case (mode_i)
      MODE_SEARCH: word_o = {idx_i - 8'd1, idx_i - 8'd2};
      MODE_FIX_LO: word_o = 16'(((q32 + 32'd1) << 8) + 32'(FIX_LO_BYTE));
      MODE_FIX_HI: word_o = 16'((32'(FIX_HI_BYTE) << 8) + q32);
      default:     word_o = 16'h0000;
    endcase
  end
endmodule

// File: rtl/prescale_calc.sv
module prescale_calc
  import prescale_pkg::*;
#(
  parameter int unsigned SCLK_W = 16,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [SCLK_W-1:0] sclk_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       prescale_o
);
  localparam int unsigned DW = SCLK_W + 4;

  pstate_e       state_q;
  pmode_e        mode_q;
  logic [DW-1:0] nm_q, res_q;
  logic [7:0]    idx_q;

  logic          div_go, div_busy, div_done;
  logic [DW-1:0] div_a, div_b, div_q;
  logic          hit;
  logic [15:0]   word;
  pmode_e        mode_in;

  assign mode_in = pmode_e'(mode_i);
  assign hit     = div_q < DW'(idx_q);

  always_comb begin
    div_go = 1'b0;
    div_a  = DW'(sclk_i) * DW'(10);
    div_b  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i && mode_in != MODE_ZERO) begin
        div_go = 1'b1;
        unique case (mode_in)
          MODE_SEARCH: div_b = DW'(rate_i) << 2;
          MODE_FIX_LO: div_b = DW'(FIX_LO_DIVISOR);
          default:     div_b = DW'(rate_i) * DW'(FIX_HI_SCALE);
        endcase
      end
      ST_PRE: if (div_done && mode_q == MODE_SEARCH) begin
        div_go = 1'b1;
        div_a  = div_q;
        div_b  = DW'(1);
      end
      ST_SEARCH: if (div_done && !hit && idx_q != 8'(IDX_LAST)) begin
        div_go = 1'b1;
        div_a  = nm_q;
        div_b  = DW'(idx_q) + DW'(1);
      end
      default: ;
    endcase
  end

  prescale_div #(.W(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (div_go),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_q)
  );

  prescale_pack #(.W(DW)) u_pack (
    .mode_i (mode_q),
    .quot_i (res_q),
    .idx_i  (idx_q),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_SEARCH;
      nm_q       <= '0;
      res_q      <= '0;
      idx_q      <= 8'd1;
      done_o     <= 1'b0;
      prescale_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_in;
          state_q <= (mode_in == MODE_ZERO) ? ST_FIN : ST_PRE;
        end
        ST_PRE: if (div_done) begin
          if (mode_q == MODE_SEARCH) begin
            nm_q    <= div_q;
            idx_q   <= 8'd1;
            state_q <= ST_SEARCH;
          end else begin
            res_q   <= div_q;
            state_q <= ST_FIN;
          end
        end
        ST_SEARCH: if (div_done) begin
          if (hit) begin
            state_q <= ST_FIN;
          end else if (idx_q == 8'(IDX_LAST)) begin
            idx_q   <= 8'd255;  // saturate
            state_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + 8'd1;
          end
        end
        default: begin
          done_o     <= 1'b1;
          prescale_o <= word;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(prescale_o));
  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));
  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> (idx_q >= 8'd1 && idx_q <= 8'(IDX_LAST)));
  p_div_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !div_busy);
endmodule

// File: tb/prescale_calc_tb_top.sv
`timescale 1ns/1ps
module prescale_calc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] sclk_i = '0;
  logic [7:0]  rate_i = '0;
  logic        busy_o, done_o;
  logic [15:0] prescale_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] held = '0;
  logic        prev_done = 1'b0;

  always #10 clk_i = ~clk_i;

  prescale_calc dut_i (
    .clk_i, .rst_ni, .start_i, .mode_i, .sclk_i, .rate_i,
    .busy_o, .done_o, .prescale_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int mode, input int sclk, input int rate);
    int nm, idx;
    case (mode)
      0: begin
        nm  = (sclk * 10) / (rate * 4);
        idx = 255;
        for (int i = 1; i <= 254; i++) begin
          if (nm / i < i) begin idx = i; break; end
        end
        return {8'(idx - 1), 8'(idx - 2)};
      end
      1: return 16'((((sclk * 10) / 51200) + 1) * 256 + 128);
      2: return 16'(127 * 256 + (sclk * 10) / (508 * rate));
      default: return 16'h0000;
    endcase
  endfunction

  // per-cycle reference: output held except on strobe, strobe one cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!done_o) chk(prescale_o === held, "R10 hold", prescale_o, held);
      if (done_o) chk(!prev_done, "R8 pulse", done_o, 0);
      if (done_o) held = prescale_o;
      prev_done = done_o;
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (done_o !== 1'b1 && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    chk(done_o === 1'b1, req, done_o, 1);
  endtask

  task automatic run(input int mode, input int sclk, input int rate, input string req);
    logic [15:0] exp = model(mode, sclk, rate);
    @(negedge clk_i);
    mode_i = 2'(mode); sclk_i = 16'(sclk); rate_i = 8'(rate); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R8 busy", busy_o, 1);
    wait_done(req);
    chk(prescale_o === exp, req, prescale_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
    chk(done_o === 1'b0, "R1 done", done_o, 0);
    chk(prescale_o === 16'h0, "R1 word", prescale_o, 0);
    rst_ni = 1'b1;

    run(0, 20000, 60, "R2 search");
    run(0, 65535, 60, "R2 search");
    run(0, 5000, 60, "R2 search");
    run(0, 1234, 7, "R2 search");
    run(0, 0, 60, "R3 wrap");
    run(0, 65535, 1, "R4 saturate");
    run(1, 20000, 0, "R5 fixed low");
    run(1, 65535, 0, "R5 fixed low");
    run(1, 0, 0, "R5 fixed low");
    run(2, 20000, 50, "R6 fixed high");
    run(2, 100, 1, "R6 fixed high");
    run(2, 65535, 1, "R6 fixed high");
    run(3, 20000, 60, "R7 zero");

    // R9: start during a computation is ignored
    begin
      logic [15:0] exp = model(0, 20000, 60);
      @(negedge clk_i);
      mode_i = 2'd0; sclk_i = 16'd20000; rate_i = 8'd60; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (3) @(negedge clk_i);
      mode_i = 2'd1; sclk_i = 16'd65535; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R9 busy", busy_o, 1);
      wait_done("R9 done");
      chk(prescale_o === exp, "R9 result", prescale_o, exp);
      repeat (40) @(negedge clk_i);
      chk(busy_o === 1'b0, "R9 no restart", busy_o, 0);
      chk(prescale_o === exp, "R9 held", prescale_o, exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule